// File: doc/BRIEF.md
# Per-core inter-processor interrupt mailbox

This block lets one processor core raise an interrupt at another core and leave short messages for it. Every core owns a 256-byte register window. The window holds a 32-bit pending-status word, a 32-bit enable word, two write-only ports, and four 64-bit message slots. One write-only port sets pending bits and the other clears them. A core's interrupt line is high for as long as its pending-status word holds any one bit.

A sender posts its message into the target core's slots and then writes a bit pattern into that core's set port. The receiver takes the interrupt, reads its status and slots, and writes the bits it has handled into its clear port. The bus side is a plain register interface: a select, a write strobe, a core index that picks the window, an 8-bit offset inside the window, a width flag for 4-byte or 8-byte accesses, write data, and read data returned one cycle after the access.

Top module: `ipi_mbox`

## Requirements
- R1: After reset, every status, enable and message slot reads as zero and every interrupt output is low.
- R2: `bus_core` selects the window for an access. An access changes only the selected core's state, and a read returns only that core's registers.
- R3: A 4-byte access at offset 0x04 writes or reads the enable word. The enable value has no effect on the interrupt output.
- R4: A 4-byte write at offset 0x08 ORs `bus_wdata[31:0]` into status. If status is then non-zero, the core's interrupt is high from the clock edge that takes the write.
- R5: A 4-byte write at offset 0x0C makes status equal to status AND NOT `bus_wdata[31:0]`. The interrupt goes low at that edge if status becomes zero.
- R6: A 4-byte read at offset 0x00 returns status. A write to offset 0x00 leaves status and the interrupt unchanged.
- R7: 4-byte reads at offsets 0x08 and 0x0C return zero.
- R8: An 8-byte access (`bus_wide`=1) at offset 0x20+8*s, for s from 0 to 3, writes or reads all 64 bits of slot s.
- R9: A 4-byte access at offset 0x20+4*k reaches slot k/2. Even k selects bits 31:0 and odd k selects bits 63:32, which is little-endian order. A 4-byte read returns the value in bits 31:0 with bits 63:32 zero.
- R10: All other accesses are unmapped. This includes any other offset, 4-byte accesses whose offset has a non-zero bit 1 or bit 0, and 8-byte accesses whose offset is not a slot base. A write to an unmapped offset changes nothing, and a read returns zero.
- R11: Read data appears on `bus_rdata` in the cycle after the read is accepted. In every other cycle `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_core | input | CW (4) | Core window index |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the read |
| core_irq | output | NCORES (16) | Interrupt output per core |

## Verification
The bench sweeps every offset in both widths and checks each read against a map it builds itself. A decoder that treated a misaligned or wrongly sized access as mapped would return slot or status data where zero is expected. It then writes all ones to every unmapped offset. A decode hole would show up as corrupted status, enable or slot contents when they are read back. Partial clears check that only the bits written as one are removed, so a clear done by XOR would set bits again on a repeated clear. The checks also confirm that the interrupt stays high until the last bit is gone, and that it ignores the enable word. Half-slot writes followed by whole-slot reads would expose swapped halves.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned NSLOTS = 4;
  localparam int unsigned SLOT_W = $clog2(NSLOTS);

  typedef enum logic [2:0] {
    RG_NONE, RG_STAT, RG_EN, RG_SET, RG_CLR, RG_SLOT
  } region_e;

  function automatic logic [STAT_W-1:0] st_clear(input logic [STAT_W-1:0] s,
                                                 input logic [STAT_W-1:0] d);
    return s & ~d;
  endfunction

  function automatic logic [DATA_W-1:0] slot_merge(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] d,
                                                   input logic wide, input logic hi);
    if (wide) return d;
    if (hi) return {d[31:0], old[31:0]};
    return {old[63:32], d[31:0]};
  endfunction

  function automatic logic [DATA_W-1:0] slot_view(input logic [DATA_W-1:0] v,
                                                  input logic wide, input logic hi);
    if (wide) return v;
    if (hi) return {32'b0, v[63:32]};
    return {32'b0, v[31:0]};
  endfunction
endpackage

// File: rtl/ipi_offset_decode.sv
module ipi_offset_decode
  import ipi_mbox_pkg::*;
(
  input  logic [7:0]        addr,
  input  logic              wide,
  output region_e           region,
  output logic [SLOT_W-1:0] slot,
  output logic              hi
);
  always_comb begin
    region = RG_NONE;
    slot   = addr[4:3];
    hi     = 1'b0;
    if (!wide) begin
      if (addr[1:0] == 2'b00) begin
        if (addr[7:5] == 3'b001) begin
          region = RG_SLOT;
          hi     = addr[2];
        end else begin
          unique case (addr)
            8'h00: region = RG_STAT;
            8'h04: region = RG_EN;
            8'h08: region = RG_SET;
            8'h0C: region = RG_CLR;
            default: region = RG_NONE;
          endcase
        end
      end
    end else if (addr[7:5] == 3'b001 && addr[2:0] == 3'b000) begin
      region = RG_SLOT;
    end
  end
endmodule

// File: rtl/ipi_core_slice.sv
module ipi_core_slice
  import ipi_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              we,
  input  region_e           region,
  input  logic [SLOT_W-1:0] slot,
  input  logic              hi,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [STAT_W-1:0] st_q, st_nxt, en_q;
  logic [NSLOTS-1:0][DATA_W-1:0] slot_q;
  logic irq_q;

  wire wr_any  = acc && we;
  wire wr_set  = wr_any && region == RG_SET;
  wire wr_clr  = wr_any && region == RG_CLR;
  wire wr_stat = wr_any && region == RG_STAT;
  wire wr_en   = wr_any && region == RG_EN;
  wire wr_slot = wr_any && region == RG_SLOT;

  always_comb begin
    st_nxt = st_q;
    if (wr_set) st_nxt = st_q | wdata[STAT_W-1:0];
    else if (wr_clr) st_nxt = st_clear(st_q, wdata[STAT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      slot_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      irq_q <= |st_nxt;
      if (wr_en) en_q <= wdata[STAT_W-1:0];
      for (int s = 0; s < NSLOTS; s++)
        if (wr_slot && slot == SLOT_W'(s))
          slot_q[s] <= slot_merge(slot_q[s], wdata, wide, hi);
    end
  end

  always_comb begin
    rdata = '0;
    if (acc && !we) begin
      unique case (region)
        RG_STAT: rdata = {32'b0, st_q};
        RG_EN:   rdata = {32'b0, en_q};
        RG_SLOT: rdata = slot_view(slot_q[slot], wide, hi);
        default: rdata = '0;
      endcase
    end
  end

  assign irq = irq_q;

  // R4
  set_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && (|wdata[STAT_W-1:0]) |=> irq_q);
  // R5
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && ((st_q & ~wdata[STAT_W-1:0]) == '0) |=> !irq_q);
  // R6
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> $stable(st_q) && $stable(irq_q));
  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slot |=> $stable(slot_q));
  // R3
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|st_q));
endmodule

// File: rtl/ipi_mbox.sv
module ipi_mbox
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned NCORES = 16,
  localparam int unsigned CW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [CW-1:0]     bus_core,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wide,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic [NCORES-1:0] core_irq
);
  region_e           region;
  logic [SLOT_W-1:0] slot;
  logic              hi;
  logic [NCORES-1:0] core_acc;
  logic [NCORES-1:0][DATA_W-1:0] core_rd;
  logic [DATA_W-1:0] rd_or, rdata_q;

  ipi_offset_decode u_dec (
    .addr(bus_addr), .wide(bus_wide), .region(region), .slot(slot), .hi(hi)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    assign core_acc[c] = bus_sel && bus_core == CW'(c);
    ipi_core_slice u_slice (
      .clk(clk), .rst_n(rst_n), .acc(core_acc[c]), .we(bus_we),
      .region(region), .slot(slot), .hi(hi), .wide(bus_wide),
      .wdata(bus_wdata), .rdata(core_rd[c]), .irq(core_irq[c])
    );
  end

  always_comb begin
    rd_or = '0;
    for (int c = 0; c < NCORES; c++) rd_or |= core_rd[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else rdata_q <= (bus_sel && !bus_we) ? rd_or : '0;
  end

  assign bus_rdata = rdata_q;

  // R2
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_acc));
  // R11
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> bus_rdata == '0);
endmodule

// File: tb/tb_ipi_mbox.sv
module tb_ipi_mbox;
  localparam int NC = 16;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, sel = 0, we = 0, wide = 0;
  logic [3:0] core = 0;
  logic [7:0] addr = 0;
  logic [63:0] wdata = 0, rdata;
  logic [NC-1:0] irq;

  int vecs = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_st [NC];
  logic [31:0] m_en [NC];
  logic [63:0] m_sl [NC][4];

  ipi_mbox #(.NCORES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_core(core),
    .bus_addr(addr), .bus_wide(wide), .bus_wdata(wdata), .bus_rdata(rdata),
    .core_irq(irq)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(int c, int a, bit w);
    int k;
    if (w) begin
      if (a >= 32 && a < 64 && a % 8 == 0) return m_sl[c][(a-32)/8];
      return 0;
    end
    if (a % 4 != 0) return 0;
    if (a == 0) return {32'b0, m_st[c]};
    if (a == 4) return {32'b0, m_en[c]};
    if (a >= 32 && a < 64) begin
      k = (a - 32) / 4;
      return (k % 2) ? {32'b0, m_sl[c][k/2][63:32]} : {32'b0, m_sl[c][k/2][31:0]};
    end
    return 0;
  endfunction

  function automatic bit mapped(int a, bit w);
    if (w) return a >= 32 && a < 64 && a % 8 == 0;
    return a % 4 == 0 && (a < 16 || (a >= 32 && a < 64));
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = |m_st[c];
    return v;
  endfunction

  task automatic wr(int c, int a, bit w, logic [63:0] d);
    @(negedge clk);
    sel = 1; we = 1; core = 4'(c); addr = 8'(a); wide = w; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(int c, int a, bit w, output logic [63:0] v);
    @(negedge clk);
    sel = 1; we = 0; core = 4'(c); addr = 8'(a); wide = w;
    @(negedge clk);
    v = rdata;
    sel = 0;
  endtask

  task automatic check_core(string r, int c);
    logic [63:0] v;
    rd(c, 0, 0, v); chk(r, v, exp_rd(c, 0, 0));
    rd(c, 4, 0, v); chk(r, v, exp_rd(c, 4, 0));
    for (int s = 0; s < 4; s++) begin
      rd(c, 32 + 8*s, 1, v); chk(r, v, m_sl[c][s]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, d;
    for (int c = 0; c < NC; c++) begin
      m_st[c] = 0; m_en[c] = 0;
      for (int s = 0; s < 4; s++) m_sl[c][s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    for (int c = 0; c < NC; c++) check_core("R1", c);

    // R3 enable stored, irq unaffected; R2 isolation
    for (int c = 0; c < NC; c++) begin
      m_en[c] = 32'hA5000000 ^ (32'h01010101 * c);
      wr(c, 4, 0, {32'hDEAD0000, m_en[c]});
    end
    for (int c = 0; c < NC; c++) begin
      rd(c, 4, 0, v); chk("R3 R2 enable", v, {32'b0, m_en[c]});
    end
    chk("R3 irq not from enable", 64'(irq), 0);

    // R4 set / R5 clear per core, R2 only target irq
    for (int c = 0; c < NC; c++) begin
      d = 64'(32'h1 << c) | 64'h00F0_0000 | 64'hFFFF_FFFF_0000_0000;
      wr(c, 8, 0, d); m_st[c] |= d[31:0];
      chk("R4 R2 irq after set", 64'(irq), 64'(exp_irq()));
      rd(c, 0, 0, v); chk("R6 status read", v, {32'b0, m_st[c]});
      wr(c, 8, 0, 64'h0000_0300); m_st[c] |= 32'h300;
      rd(c, 0, 0, v); chk("R4 OR accumulate", v, {32'b0, m_st[c]});
      wr(c, 0, 0, 64'h0); // R6 write to status ignored
      rd(c, 0, 0, v); chk("R6 status ro", v, {32'b0, m_st[c]});
      chk("R6 irq kept", 64'(irq), 64'(exp_irq()));
      rd(c, 8, 0, v); chk("R7 set reads 0", v, 0);
      rd(c, 12, 0, v); chk("R7 clr reads 0", v, 0);
      wr(c, 12, 0, 64'h0000_0100); m_st[c] &= ~32'h100;
      rd(c, 0, 0, v); chk("R5 partial clear", v, {32'b0, m_st[c]});
      wr(c, 12, 0, 64'h0000_0100); // repeat: must not set again
      rd(c, 0, 0, v); chk("R5 repeat clear", v, {32'b0, m_st[c]});
      chk("R5 irq held", 64'(irq), 64'(exp_irq()));
    end
    for (int c = 0; c < NC; c++) begin
      wr(c, 12, 0, 64'hFFFF_FFFF); m_st[c] = 0;
      chk("R5 irq drops", 64'(irq), 64'(exp_irq()));
    end
    // R3 enable zero does not block irq
    wr(5, 4, 0, 0); m_en[5] = 0;
    wr(5, 8, 0, 64'h8000_0000); m_st[5] = 32'h8000_0000;
    chk("R3 irq with enable 0", 64'(irq), 64'(exp_irq()));
    wr(5, 12, 0, 64'h8000_0000); m_st[5] = 0;

    // R8 / R9 mailbox
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < 4; s++) begin
        d = {8'(c), 8'(s), 48'h1234_5678_9ABC} ^ 64'hF0F0_0000_0F0F_0000;
        wr(c, 32 + 8*s, 1, d); m_sl[c][s] = d;
      end
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 8; k++) begin
        rd(c, 32 + 4*k, 0, v); chk("R9 half read", v, exp_rd(c, 32 + 4*k, 0));
      end
    for (int k = 0; k < 8; k++) begin
      d = 64'hCAFE_0000_0000_0000 | 64'(32'h1111_1111 * (k + 1));
      wr(2, 32 + 4*k, 0, d);
      if (k % 2) m_sl[2][k/2][63:32] = d[31:0];
      else m_sl[2][k/2][31:0] = d[31:0];
    end
    for (int s = 0; s < 4; s++) begin
      rd(2, 32 + 8*s, 1, v); chk("R9 R8 merged slot", v, m_sl[2][s]);
    end
    for (int c = 0; c < NC; c++) check_core("R2 isolation", c);

    // R10 sweep: reads of every offset, both widths
    for (int c = 0; c < 3; c++) begin
      wr(c, 8, 0, 64'(32'h55 + c)); m_st[c] |= 32'h55 + c;
    end
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 256; a++)
        for (int w = 0; w < 2; w++) begin
          rd(c, a, w[0], v); chk("R10 R11 sweep read", v, exp_rd(c, a, w[0]));
        end
    // R10 writes of all ones to unmapped offsets
    for (int a = 0; a < 256; a++)
      for (int w = 0; w < 2; w++)
        if (!mapped(a, w[0])) wr(1, a, w[0], '1);
    check_core("R10 unmapped write", 1);
    chk("R10 irq", 64'(irq), 64'(exp_irq()));
    // R11 rdata zero when idle
    @(negedge clk);
    chk("R11 idle rdata", rdata, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule